// File: doc/BRIEF.md
# Three-Period Synchronous Bus Read

This block pairs a bus master with a memory target and carries out single-word reads over a shared synchronous bus. A requester asks for a word by raising a read request with an address. The master accepts the request only while it is idle. It then runs a fixed read of three clock periods on the bus.

In the first period the master puts the address on the bus and raises the memory-read strobe. The target uses the second period to read its internal storage and keeps its data output off the bus. In the third period the target drives the word onto the bus. Both sides sample bus lines on the falling clock edge, halfway through a period. The master captures the word on the falling edge inside the third period. It drops the strobe at the end of that period and returns the word together with a one-cycle done pulse.

A request that arrives while a read is running is refused through a busy output and is not remembered. The target storage is a block-RAM-style array. Its contents are fixed at start-up from a simple arithmetic fill rule.

Top module: `sbr_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge: `req_busy`, `rsp_done`, `rsp_data`, `bus_addr`, `bus_rd`, `bus_data` and `bus_data_oe`.
- R2: A request is accepted when `req_valid` is high at a rising edge while `req_busy` is low. `bus_rd` is then high for exactly the next three cycles (T1, T2, T3).
- R3: During T1 to T3, `bus_addr` holds the accepted `req_addr` without change. In every other cycle `bus_addr` is zero.
- R4: `bus_data_oe` is high only in T3. In all other cycles, T1 and T2 included, `bus_data_oe` is low and `bus_data` is zero.
- R5: In T3, `bus_data` carries storage word i, where i is the low log2(DEPTH) bits of the address. Higher address bits are ignored. Word i holds (i*40503 + 4660) mod 2^DATA_W.
- R6: The master takes the word from the bus on the falling edge inside T3. It shows that word on `rsp_data` from the cycle after T3 and holds it until the next completed read.
- R7: `rsp_done` is high for exactly one cycle, the cycle right after T3.
- R8: `req_busy` is high from T1 through the done cycle. A request seen while `req_busy` is high is dropped: no later read starts from it.
- R9: The earliest point at which a new request can be accepted is the rising edge that ends the cycle after the done pulse. Back-to-back reads therefore start five cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus lines are sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request from the requester |
| req_addr | input | ADDR_W | Address of the requested word |
| req_busy | output | 1 | A read is in progress; requests are refused |
| rsp_data | output | DATA_W | Word returned by the last completed read |
| rsp_done | output | 1 | One-cycle pulse when `rsp_data` is updated |
| bus_addr | output | ADDR_W | Bus address lines driven by the master |
| bus_rd | output | 1 | Bus memory-read strobe |
| bus_data | output | DATA_W | Bus data lines driven by the target |
| bus_data_oe | output | 1 | Target data output enable |

## Verification
A wrong phase in either the master or the target shows at the ports within one cycle. The strobe, address, output enable and busy lines together spell out the current period, and the bench rebuilds that period from the request history alone. A wrong target phase turns `bus_data_oe` on in T2 or leaves it on after T3. A wrong capture or storage index shows as a wrong `bus_data` word in T3, or as a wrong `rsp_data` word in the done cycle. Requests sent during a read, aliased addresses, back-to-back reads and a reset in the middle of a read show whether the master drops, starts or aborts reads on the right edge.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [2:0] {
    MS_IDLE = 3'd0,
    MS_T1   = 3'd1,
    MS_T2   = 3'd2,
    MS_T3   = 3'd3,
    MS_DONE = 3'd4
  } mst_state_t;

  typedef enum logic [1:0] {
    TS_IDLE   = 2'd0,
    TS_ACCESS = 2'd1,
    TS_DRIVE  = 2'd2
  } tgt_state_t;

  localparam logic [63:0] FILL_MUL = 64'd40503;
  localparam logic [63:0] FILL_ADD = 64'd4660;

  // start-up content of storage word idx, wide enough for any DATA_W up to 64
  function automatic logic [63:0] sbr_fill(input int unsigned idx);
    return 64'(idx) * FILL_MUL + FILL_ADD;
  endfunction

endpackage

// File: rtl/sbr_store.sv
module sbr_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q
);
  import sbr_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(sbr_fill(i));
    end
  end

  // registered read port, block-RAM friendly
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem[rd_idx];
    end
  end

endmodule

// File: rtl/sbr_target.sv
module sbr_target #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_data_oe
);
  import sbr_pkg::*;

  tgt_state_t        state;
  logic              rd_seen;
  logic [IDX_W-1:0]  idx_seen;
  logic              rd_en;
  logic [DATA_W-1:0] mem_q;

  // bus lines sensed on the trailing edge
  always_ff @(negedge clk) begin
    if (rst) begin
      rd_seen  <= 1'b0;
      idx_seen <= '0;
    end else begin
      rd_seen  <= bus_rd;
      idx_seen <= bus_addr[IDX_W-1:0];
    end
  end

  assign rd_en = (state == TS_IDLE) && rd_seen;

  sbr_store #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk   (clk),
    .rd_en (rd_en),
    .rd_idx(idx_seen),
    .rd_q  (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= TS_IDLE;
      bus_data    <= '0;
      bus_data_oe <= 1'b0;
    end else begin
      case (state)
        TS_IDLE: begin
          if (rd_seen) state <= TS_ACCESS;
        end
        TS_ACCESS: begin
          bus_data    <= mem_q;
          bus_data_oe <= 1'b1;
          state       <= TS_DRIVE;
        end
        TS_DRIVE: begin
          bus_data    <= '0;
          bus_data_oe <= 1'b0;
          state       <= TS_IDLE;
        end
        default: state <= TS_IDLE;
      endcase
    end
  end

  // R4: no data on the bus during the access period
  p_quiet_access_r4: assert property (@(posedge clk) disable iff (rst)
    (state == TS_ACCESS) |-> !bus_data_oe);

  // R4: the target drives data for one period only
  p_drive_once_r4: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |=> !bus_data_oe);

endmodule

// File: rtl/sbr_master.sv
module sbr_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_busy,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_data_in
);
  import sbr_pkg::*;

  mst_state_t        state;
  logic [DATA_W-1:0] cap_q;

  assign req_busy = (state != MS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MS_IDLE;
      bus_addr <= '0;
      bus_rd   <= 1'b0;
      rsp_data <= '0;
      rsp_done <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        MS_IDLE: begin
          if (req_valid) begin
            bus_addr <= req_addr;
            bus_rd   <= 1'b1;
            state    <= MS_T1;
          end
        end
        MS_T1: state <= MS_T2;
        MS_T2: state <= MS_T3;
        MS_T3: begin
          bus_rd   <= 1'b0;
          bus_addr <= '0;
          rsp_data <= cap_q;
          rsp_done <= 1'b1;
          state    <= MS_DONE;
        end
        MS_DONE: state <= MS_IDLE;
        default: state <= MS_IDLE;
      endcase
    end
  end

  // data is taken from the bus on the trailing edge, only inside T3
  always_ff @(negedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (state == MS_T3) begin
      cap_q <= bus_data_in;
    end
  end

  // R2: the strobe ends after the third period
  p_rd_three_r2: assert property (@(posedge clk) disable iff (rst)
    (state == MS_T3) |=> !bus_rd);

  // R3: address held through the read
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((state == MS_T2) || (state == MS_T3)) |-> ($stable(bus_addr) && bus_rd));

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

// File: rtl/sbr_top.sv
module sbr_top #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_busy,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_data_oe
);

  sbr_master #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_master (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_busy   (req_busy),
    .rsp_data   (rsp_data),
    .rsp_done   (rsp_done),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_data_in(bus_data)
  );

  sbr_target #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_target (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_data   (bus_data),
    .bus_data_oe(bus_data_oe)
  );

  // R4: the target drives only inside a read started by the master
  p_oe_in_read_r4: assert property (@(posedge clk) disable iff (rst)
    bus_data_oe |-> bus_rd);

  // R7: done follows the data period
  p_done_after_drive_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(bus_data_oe));

  // R8: busy whenever the strobe is up
  p_busy_in_read_r8: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> req_busy);

endmodule

// File: tb/sbr_top_test.sv
module sbr_top_test;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_busy;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_done;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_rd;
  logic [DATA_W-1:0] bus_data;
  logic              bus_data_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2 clk = ~clk;  // 250 MHz

  sbr_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_busy(req_busy), .rsp_data(rsp_data), .rsp_done(rsp_done),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_data(bus_data),
    .bus_data_oe(bus_data_oe)
  );

  // expected word for an address, from the fill rule in R5
  function automatic logic [DATA_W-1:0] exp_word(input logic [ADDR_W-1:0] a);
    int unsigned i;
    i = int'(a) % DEPTH;
    return DATA_W'((i * 40503 + 4660) % 65536);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: ph 0 idle, 1..3 bus periods, 4 done cycle
  int                ph = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [DATA_W-1:0] m_rsp = '0;
  bit                in_rst;

  initial begin
    forever begin
      @(posedge clk);
      in_rst = rst;
      if (rst) begin
        ph = 0; m_addr = '0; m_rsp = '0;
      end else begin
        case (ph)
          0: if (req_valid) begin ph = 1; m_addr = req_addr; end
          1: ph = 2;
          2: ph = 3;
          3: begin ph = 4; m_rsp = exp_word(m_addr); end
          default: ph = 0;
        endcase
      end
      #1;
      if (in_rst) begin
        chk("R1 reset outputs", {req_busy, rsp_done, bus_rd, bus_data_oe}, 0);
      end
      chk("R8 req_busy", 32'(req_busy), 32'(ph != 0));
      chk("R2 bus_rd", 32'(bus_rd), 32'(ph >= 1 && ph <= 3));
      chk("R3 bus_addr", 32'(bus_addr), (ph >= 1 && ph <= 3) ? 32'(m_addr) : 0);
      chk("R4 bus_data_oe", 32'(bus_data_oe), 32'(ph == 3));
      chk("R5 bus_data", 32'(bus_data), (ph == 3) ? 32'(exp_word(m_addr)) : 0);
      chk("R7 rsp_done", 32'(rsp_done), 32'(ph == 4));
      chk("R6 rsp_data", 32'(rsp_data), 32'(m_rsp));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ask(input logic [ADDR_W-1:0] a);
    req_valid = 1'b1; req_addr = a;
    step(1);
    req_valid = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(2);
    // R2 R3 R5 R6 R7: plain read
    ask(16'h0005); step(6);
    // R5: alias of index 5, upper bits ignored
    ask(16'h0105); step(6);
    ask(16'hFFFF); step(6);
    ask(16'h0000); step(6);
    // R8: requests while busy are dropped
    ask(16'h0011);
    req_valid = 1'b1; req_addr = 16'h0022; step(2);
    req_valid = 1'b0; step(6);
    // R9: request held high, reads start five cycles apart
    req_valid = 1'b1; req_addr = 16'h0033; step(3);
    req_addr = 16'h0044; step(9);
    req_valid = 1'b0; step(6);
    // R1: reset in the middle of a read
    ask(16'h0077); step(1);
    rst = 1'b1; step(2);
    rst = 1'b0; step(4);
    ask(16'h00FE); step(6);
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule